// File: doc/BRIEF.md
# Chien Search Root Finder with Bit Correction

This block finishes the decoding of a triple-error-correcting binary BCH word of length 31 over GF(2^5). It receives a locator polynomial with up to four coefficients (Λ0..Λ3) and the stored 31-bit received word in a single load strobe. It then visits every non-zero field element α^j, one per clock, and checks whether the locator vanishes there. Each root maps to one bit position of the word, and that bit is inverted.

The locator is never evaluated from scratch. One register per coefficient holds the running term Λi·α^(i·j). On each step that register is multiplied by the constant α^i, which is a small fixed XOR network. After the last step the block pulses a done strobe and presents three results: the corrected word, the number of roots found, and an uncorrectable flag. The flag is raised when the root count disagrees with the locator's degree. In that case the received word is passed through unmodified.

Top module: `chien_corrector`

## Requirements
- R1: While rst_ni is low and after its release with no load, done_o, uncorr_o, root_cnt_o and data_o are all zero.
- R2: When load_i is sampled high at clock edge k, done_o is high for exactly the one cycle that follows edge k+31.
- R3: Field arithmetic uses the modulus x^5+x^2+1, with α = 5'b00010 and coefficient Λi on lam_i[5i+4:5i]. If Λ0 + Λ1·α^j + Λ2·α^2j + Λ3·α^3j = 0 for a step j in 1..31, then bit (31−j) mod 31 of the received word is inverted in data_o. Every other bit is copied unchanged. As a result, the locator Π(1+α^p·x) inverts exactly the bits p.
- R4: root_cnt_o gives the number of steps j in 1..31 at which the locator evaluates to zero.
- R5: The degree of the locator is the largest i in 1..3 with Λi ≠ 0, or 0 if Λ1..Λ3 are all zero. If the root count differs from this degree, uncorr_o is 1 and data_o equals the received word. Otherwise uncorr_o is 0.
- R6: A load during a running search abandons that search: it produces no done pulse and its results are discarded. The new search completes on the timing of R2.
- R7: data_o, root_cnt_o and uncorr_o change only on the edge that raises done_o, and hold their value until the next such edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Start strobe; captures lam_i and rx_i |
| lam_i | input | 20 | Locator coefficients, Λi in bits [5i+4:5i] |
| rx_i | input | 31 | Received word |
| done_o | output | 1 | One-cycle result strobe |
| data_o | output | 31 | Corrected word, or the received word if uncorrectable |
| root_cnt_o | output | 5 | Number of roots found |
| uncorr_o | output | 1 | Root count differs from locator degree |

## Verification
The bench covers single errors at both ends of the word (bits 0 and 30). A design that gets the step-to-position mapping wrong shifts the inverted bit by one place, or wraps it onto the wrong end.

It also applies locators with only one or no roots despite a degree of 3. It applies an all-zero locator that vanishes at every step. These inputs expose a design that corrects when it should pass the word through, or that overflows the root counter.

A reload in mid-search checks that no stale done pulse escapes from the abandoned search. A zero-error word checks that nothing is altered when the locator is the constant 1.

// File: rtl/chien_pkg.sv
package chien_pkg;
  localparam int unsigned M    = 5;              // field degree
  localparam int unsigned N    = (1 << M) - 1;   // code length
  localparam int unsigned T    = 3;              // correctable errors
  localparam int unsigned CW   = $clog2(N + 1);  // root count / step width
  localparam logic [M-1:0] RED = 5'b00101;       // x^5 = x^2 + 1

  typedef logic [M-1:0] gf_t;

  function automatic gf_t mul_alpha(gf_t v);
    return {v[M-2:0], 1'b0} ^ (v[M-1] ? RED : '0);
  endfunction

  function automatic gf_t mul_alpha_pow(gf_t v, int unsigned k);
    gf_t r = v;
    for (int unsigned n = 0; n < k; n++) r = mul_alpha(r);
    return r;
  endfunction
endpackage

// File: rtl/chien_term.sv
module chien_term
  import chien_pkg::*;
#(
  parameter int unsigned K = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic step_i,
  input  gf_t  coef_i,
  output gf_t  term_o
);
  gf_t term_q;

  // first evaluation point is alpha^1, so preload coef*alpha^K
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      term_q <= '0;
    else if (load_i)  term_q <= mul_alpha_pow(coef_i, K);
    else if (step_i)  term_q <= mul_alpha_pow(term_q, K);
  end

  assign term_o = term_q;
endmodule

// File: rtl/chien_ctrl.sv
module chien_ctrl
  import chien_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  output logic          busy_o,
  output logic          last_o,
  output logic [CW-1:0] step_o
);
  logic          busy_q;
  logic [CW-1:0] step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      step_q <= '0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      step_q <= CW'(1);
    end else if (busy_q) begin
      if (step_q == CW'(N)) busy_q <= 1'b0;
      step_q <= step_q + CW'(1);
    end
  end

  assign busy_o = busy_q;
  assign last_o = busy_q && (step_q == CW'(N));
  assign step_o = step_q;
endmodule

// File: rtl/chien_corrector.sv
module chien_corrector
  import chien_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [(T+1)*M-1:0] lam_i,
  input  logic [N-1:0]       rx_i,
  output logic               done_o,
  output logic [N-1:0]       data_o,
  output logic [CW-1:0]      root_cnt_o,
  output logic               uncorr_o
);
  logic          busy, last;
  logic [CW-1:0] step;
  gf_t           lam0_q;
  gf_t           term [1:T];
  logic [N-1:0]  rx_q, corr_q, corr_nxt;
  logic [CW-1:0] cnt_q, cnt_nxt, deg_q, deg_in;
  logic [CW-1:0] pos;
  gf_t           sum;
  logic          hit;

  chien_ctrl u_ctrl (
    .clk_i, .rst_ni, .load_i,
    .busy_o(busy), .last_o(last), .step_o(step)
  );

  for (genvar i = 1; i <= T; i++) begin : g_term
    chien_term #(.K(i)) u_term (
      .clk_i, .rst_ni, .load_i,
      .step_i(busy),
      .coef_i(lam_i[i*M +: M]),
      .term_o(term[i])
    );
  end

  always_comb begin
    sum = lam0_q;
    for (int i = 1; i <= T; i++) sum ^= term[i];
  end

  always_comb begin
    deg_in = '0;
    for (int i = 1; i <= T; i++)
      if (lam_i[i*M +: M] != '0) deg_in = CW'(i);
  end

  // root alpha^j marks error position (N - j) mod N
  assign pos      = (step == CW'(N)) ? '0 : CW'(N) - step;
  assign hit      = busy && (sum == '0);
  assign corr_nxt = corr_q ^ (hit ? (N'(1) << pos) : '0);
  assign cnt_nxt  = cnt_q + CW'(hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lam0_q <= '0;
      rx_q   <= '0;
      corr_q <= '0;
      cnt_q  <= '0;
      deg_q  <= '0;
    end else if (load_i) begin
      lam0_q <= lam_i[M-1:0];
      rx_q   <= rx_i;
      corr_q <= rx_i;
      cnt_q  <= '0;
      deg_q  <= deg_in;
    end else if (busy) begin
      corr_q <= corr_nxt;
      cnt_q  <= cnt_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o     <= 1'b0;
      data_o     <= '0;
      root_cnt_o <= '0;
      uncorr_o   <= 1'b0;
    end else begin
      done_o <= last && !load_i;
      if (last && !load_i) begin
        root_cnt_o <= cnt_nxt;
        uncorr_o   <= (cnt_nxt != deg_q);
        data_o     <= (cnt_nxt != deg_q) ? rx_q : corr_nxt;
      end
    end
  end
endmodule

// File: rtl/chien_corrector_chk.sv
module chien_corrector_chk
  import chien_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               load_i,
  input logic [N-1:0]       rx_i,
  input logic               done_o,
  input logic [N-1:0]       data_o,
  input logic [CW-1:0]      root_cnt_o,
  input logic               uncorr_o
);
  logic [CW-1:0] since_q;
  logic          armed_q;
  logic [N-1:0]  rx_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q   <= '0;
      armed_q   <= 1'b0;
      rx_seen_q <= '0;
    end else if (load_i) begin
      since_q   <= '0;
      armed_q   <= 1'b1;
      rx_seen_q <= rx_i;
    end else if (armed_q) begin
      since_q <= since_q + CW'(1);
      if (since_q == CW'(N)) armed_q <= 1'b0;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R2
  AST_DONE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (armed_q && since_q == CW'(N))); // R6
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(data_o) && $stable(root_cnt_o) && $stable(uncorr_o))); // R7
  AST_PASS_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && uncorr_o) |-> (data_o == rx_seen_q)); // R5
  AST_FLIP_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !uncorr_o) |-> ($countones(data_o ^ rx_seen_q) == int'(root_cnt_o))); // R3
  AST_DEGREE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !uncorr_o) |-> (root_cnt_o <= CW'(T))); // R4
endmodule

bind chien_corrector chien_corrector_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .rx_i(rx_i),
  .done_o(done_o), .data_o(data_o), .root_cnt_o(root_cnt_o), .uncorr_o(uncorr_o)
);

// File: tb/chien_corrector_tb_top.sv
`timescale 1ns/1ps
module chien_corrector_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [19:0] lam = '0;
  logic [30:0] rx = '0;
  logic        done;
  logic [30:0] data;
  logic [4:0]  cnt;
  logic        unc;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  chien_corrector dut_i (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .lam_i(lam), .rx_i(rx),
    .done_o(done), .data_o(data), .root_cnt_o(cnt), .uncorr_o(unc)
  );

  function automatic logic [4:0] gmul(logic [4:0] a, logic [4:0] b);
    logic [9:0] p = '0;
    for (int i = 0; i < 5; i++) if (b[i]) p ^= 10'(a) << i;
    for (int i = 9; i >= 5; i--) if (p[i]) p ^= 10'b100101 << (i - 5);
    return p[4:0];
  endfunction

  function automatic logic [4:0] apow(int e);
    logic [4:0] r = 5'd1;
    for (int i = 0; i < e; i++) r = gmul(r, 5'd2);
    return r;
  endfunction

  // locator with roots at the inverses of alpha^p for the listed positions
  function automatic logic [19:0] loc(int n, int p0, int p1, int p2);
    logic [4:0] c [4];
    int ps [3];
    ps = '{p0, p1, p2};
    c = '{5'd1, 5'd0, 5'd0, 5'd0};
    for (int r = 0; r < n; r++)
      for (int k = 3; k >= 1; k--) c[k] = c[k] ^ gmul(apow(ps[r]), c[k-1]);
    return {c[3], c[2], c[1], c[0]};
  endfunction

  // behavioural reference
  logic [30:0] m_data = '0;
  int          m_cnt = 0;
  bit          m_unc = 0, m_done = 0, m_busy = 0, m_restart = 0;
  int          m_age = 0;
  logic [30:0] p_data;
  int          p_cnt;
  bit          p_unc;

  task automatic ref_eval(input logic [19:0] l, input logic [30:0] w);
    logic [30:0] c = w;
    int roots = 0, deg = 0;
    for (int p = 0; p < 31; p++) begin
      logic [4:0] x = apow((31 - p) % 31);
      logic [4:0] s = l[4:0] ^ gmul(l[9:5], x) ^ gmul(l[14:10], gmul(x, x))
                      ^ gmul(l[19:15], gmul(x, gmul(x, x)));
      if (s == 0) begin roots++; c[p] = ~c[p]; end
    end
    for (int i = 1; i <= 3; i++) if (l[i*5 +: 5] != 0) deg = i;
    p_cnt  = roots;
    p_unc  = (roots != deg);
    p_data = p_unc ? w : c;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_data = '0; m_cnt = 0; m_unc = 0; m_restart = 0;
    end else begin
      m_done = 0;
      if (load) begin
        m_restart = m_busy;
        m_busy = 1; m_age = 0;
        ref_eval(lam, rx);
      end else if (m_busy) begin
        m_age++;
        if (m_age == 31) begin
          m_busy = 0; m_done = 1;
          m_data = p_data; m_cnt = p_cnt; m_unc = p_unc;
        end
      end
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(m_restart ? "R6 done timing" : "R2 done timing", done, m_done);
      if (m_done) begin
        chk(m_unc ? "R5 pass-through data" : "R3 corrected data", data, m_data);
        chk("R4 root count", cnt, m_cnt);
        chk("R5 uncorrectable flag", unc, m_unc);
      end else begin
        chk("R7 data hold", data, m_data);
        chk("R7 count hold", cnt, m_cnt);
        chk("R7 flag hold", unc, m_unc);
      end
    end
  end

  task automatic run(input logic [19:0] l, input logic [30:0] w);
    @(negedge clk); load = 1; lam = l; rx = w;
    @(negedge clk); load = 0;
    repeat (34) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 done reset", done, 0);
    chk("R1 data reset", data, 0);
    chk("R1 count reset", cnt, 0);
    chk("R1 flag reset", unc, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    run(20'h00001, 31'h1234_5678);                       // no error
    run(loc(1, 0, 0, 0), 31'h0F0F_0F0F);                  // bit 0
    run(loc(1, 30, 0, 0), 31'h0000_0000);                 // bit 30
    run(loc(2, 7, 19, 0), 31'h5555_5555);
    run(loc(3, 0, 15, 30), 31'h7FFF_FFFF);
    run(loc(3, 3, 11, 27), 31'h2468_ACE1);
    run({5'd1, 5'd0, 5'd0, 5'd1}, 31'h1357_9BDF);         // degree 3, one root
    run({5'd9, 5'd4, 5'd0, 5'd1}, 31'h0ABC_DEF0);         // irregular degree 3
    run(20'h00000, 31'h3333_3333);                        // vanishes everywhere
    // R6: reload mid-search
    @(negedge clk); load = 1; lam = loc(2, 1, 2, 0); rx = 31'h0;
    @(negedge clk); load = 0;
    repeat (12) @(negedge clk);
    run(loc(3, 4, 5, 6), 31'h7000_0001);
    run(loc(1, 16, 0, 0), 31'h0001_0000);
    finish_run();
  end

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule